// File: doc/BRIEF.md
# Prioritized Scratchpad Arbiter

The block sits in front of a single-ported scratchpad memory of 256 KB and shares it among three requesters. A block-transfer (DMA) port reads and writes whole 128-byte lines. A processor port reads and writes single 16-byte quad-words. An instruction-fetch port reads whole 128-byte lines. Only one access can reach the array in a cycle, so the arbiter picks one requester by a fixed priority, steers its address, data and slice enables to the array, and stalls the other requesters.

Each port uses a ready/valid style request. The requester raises `*_req_i` and holds its command stable. The arbiter answers with `*_gnt_o`, a combinational ready. The access takes place in the cycle where both are high. A read returns its data on the port's `*_rvalid_o` a fixed number of cycles after the grant cycle. Line reads return the whole line. Processor reads return only the addressed quad-word.

Top module: `lsmem_arbiter`

## Requirements
- R1: A DMA request is granted in the same cycle it is raised, whatever the other ports do.
- R2: A processor request is granted exactly in the cycles where it is raised and no DMA request is present.
- R3: A prefetch request is granted only when neither DMA nor processor requests. A prefetch held against a continuous DMA stream is never granted. It is granted in the first cycle the stream stops.
- R4: At most one grant is high in any cycle, and a grant is only given to a requesting port.
- R5: A read granted in cycle c returns its data on its own port with rvalid high for exactly one cycle, in cycle c+6 (READ_LAT). Reads granted in consecutive cycles return in consecutive cycles. At most one rvalid is high in a cycle.
- R6: A DMA write carries 1024 data bits and 8 slice enables. Enable bit i writes bytes 16*i to 16*i+15 of the line (data bits 128*i+127 down to 128*i). Slices whose enable is low keep their old contents.
- R7: Line accesses (DMA and prefetch) select line address[17:7] and ignore address bits [6:0].
- R8: A processor write updates only quad-word address[6:4] of line address[17:7]. Address bits [3:0] are ignored. The other seven quad-words of the line are unchanged.
- R9: A processor read returns quad-word address[6:4] of line address[17:7] on the 128-bit read port.
- R10: A request that is not granted has no effect on the memory. It stays pending, without being dropped, and is served once the higher-priority requests go away.
- R11: While reset is asserted, and after it, until a read has been granted, all rvalid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_req_i | input | 1 | DMA request |
| dma_we_i | input | 1 | DMA write (1) or read (0) |
| dma_addr_i | input | 18 | DMA byte address |
| dma_wdata_i | input | 1024 | DMA write line |
| dma_qwen_i | input | 8 | DMA per-quad-word write enables |
| dma_gnt_o | output | 1 | DMA ready |
| dma_rvalid_o | output | 1 | DMA read data valid |
| dma_rdata_o | output | 1024 | DMA read line |
| cpu_req_i | input | 1 | Processor request |
| cpu_we_i | input | 1 | Processor write (1) or read (0) |
| cpu_addr_i | input | 18 | Processor byte address |
| cpu_wdata_i | input | 128 | Processor write quad-word |
| cpu_gnt_o | output | 1 | Processor ready |
| cpu_rvalid_o | output | 1 | Processor read data valid |
| cpu_rdata_o | output | 128 | Processor read quad-word |
| pf_req_i | input | 1 | Prefetch read request |
| pf_addr_i | input | 18 | Prefetch byte address |
| pf_gnt_o | output | 1 | Prefetch ready |
| pf_rvalid_o | output | 1 | Prefetch read data valid |
| pf_rdata_o | output | 1024 | Prefetch read line |

## Verification
The assertions take for granted that a requester, once it raises its request, holds it until the cycle it sees its grant. They do not check what the port does with the command after that. The stimulus changes inputs only on the falling clock edge. It drops or replaces a command only in the cycle after that command was granted, and it reads only lines it has already written. Under those terms the scoreboard keeps a line model. For every granted read it predicts the return cycle and the data, so a stall that wrongly leaked a write shows up as wrong data on a later read.

// File: rtl/lsmem_pkg.sv
package lsmem_pkg;
  localparam int unsigned NPORT = 3;

  // index order is priority order, 0 highest
  typedef enum logic [1:0] {
    PORT_DMA = 2'd0,
    PORT_CPU = 2'd1,
    PORT_PF  = 2'd2
  } port_e;
endpackage

// File: rtl/lsmem_prio.sv
module lsmem_prio #(
  parameter  int unsigned N  = 3,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] sel_o,
  output logic          any_o
);
  always_comb begin
    sel_o = '0;
    gnt_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req_i[i]) sel_o = IW'(i);
    end
    any_o = |req_i;
    if (any_o) gnt_o[sel_o] = 1'b1;
  end
endmodule

// File: rtl/lsmem_bank.sv
module lsmem_bank #(
  parameter  int unsigned LINES  = 2048,
  parameter  int unsigned LINE_W = 1024,
  parameter  int unsigned NQW    = 8,
  localparam int unsigned IDX_W  = $clog2(LINES),
  localparam int unsigned QW_W   = LINE_W / NQW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LINE_W-1:0] wdata_i,
  input  logic [NQW-1:0]    qwen_i,
  output logic [LINE_W-1:0] rdata_o
);
  logic [LINE_W-1:0] mem_q [LINES];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int q = 0; q < int'(NQW); q++) begin
        if (qwen_i[q]) mem_q[idx_i][q*QW_W +: QW_W] <= wdata_i[q*QW_W +: QW_W];
      end
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/lsmem_rpipe.sv
module lsmem_rpipe #(
  parameter int unsigned LAT = 6,
  parameter int unsigned DW  = 1024,
  parameter int unsigned MW  = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          v_i,
  input  logic [MW-1:0] meta_i,
  input  logic [DW-1:0] data_i,
  output logic          v_o,
  output logic [MW-1:0] meta_o,
  output logic [DW-1:0] data_o
);
  logic [LAT-1:0] v_q;
  logic [MW-1:0]  m_q [LAT];
  logic [DW-1:0]  d_q [LAT];

  for (genvar s = 0; s < int'(LAT); s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q[s] <= 1'b0;
        else         v_q[s] <= v_i;
      end
      always_ff @(posedge clk_i) begin
        m_q[s] <= meta_i;
        d_q[s] <= data_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) v_q[s] <= 1'b0;
        else         v_q[s] <= v_q[s-1];
      end
      always_ff @(posedge clk_i) begin
        m_q[s] <= m_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign v_o    = v_q[LAT-1];
  assign meta_o = m_q[LAT-1];
  assign data_o = d_q[LAT-1];
endmodule

// File: rtl/lsmem_arbiter.sv
module lsmem_arbiter
  import lsmem_pkg::*;
#(
  parameter  int unsigned ADDR_W     = 18,
  parameter  int unsigned LINE_BYTES = 128,
  parameter  int unsigned QW_BYTES   = 16,
  parameter  int unsigned READ_LAT   = 6,
  localparam int unsigned LINE_W     = LINE_BYTES * 8,
  localparam int unsigned QW_W       = QW_BYTES * 8,
  localparam int unsigned NQW        = LINE_BYTES / QW_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dma_req_i,
  input  logic              dma_we_i,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic [LINE_W-1:0] dma_wdata_i,
  input  logic [NQW-1:0]    dma_qwen_i,
  output logic              dma_gnt_o,
  output logic              dma_rvalid_o,
  output logic [LINE_W-1:0] dma_rdata_o,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [QW_W-1:0]   cpu_wdata_i,
  output logic              cpu_gnt_o,
  output logic              cpu_rvalid_o,
  output logic [QW_W-1:0]   cpu_rdata_o,
  input  logic              pf_req_i,
  input  logic [ADDR_W-1:0] pf_addr_i,
  output logic              pf_gnt_o,
  output logic              pf_rvalid_o,
  output logic [LINE_W-1:0] pf_rdata_o
);
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
  localparam int unsigned QOFF_W = $clog2(QW_BYTES);
  localparam int unsigned QSEL_W = $clog2(NQW);
  localparam int unsigned IDX_W  = ADDR_W - OFF_W;
  localparam int unsigned LINES  = 2 ** IDX_W;
  localparam int unsigned SEL_W  = $clog2(NPORT);
  localparam int unsigned MW     = SEL_W + QSEL_W;

  logic [NPORT-1:0]  req, gnt;
  logic [SEL_W-1:0]  sel;
  logic              any;

  logic              acc_we;
  logic [IDX_W-1:0]  acc_idx;
  logic [LINE_W-1:0] acc_wdata;
  logic [NPORT-1:0]  unused_gnt_vec;
  logic [NQW-1:0]    acc_qwen;
  logic [QSEL_W-1:0] cpu_qsel;
  logic [LINE_W-1:0] bank_rdata;

  logic              pipe_v;
  logic [MW-1:0]     pipe_meta;
  logic [LINE_W-1:0] pipe_data;
  logic [SEL_W-1:0]  pipe_port;
  logic [QSEL_W-1:0] pipe_qsel;

  logic              unused_addr_bits;

  assign req = {pf_req_i, cpu_req_i, dma_req_i};

  lsmem_prio #(.N(NPORT)) i_prio (
    .req_i (req),
    .gnt_o (gnt),
    .sel_o (sel),
    .any_o (any)
  );

  assign dma_gnt_o = gnt[PORT_DMA];
  assign cpu_gnt_o = gnt[PORT_CPU];
  assign pf_gnt_o  = gnt[PORT_PF];
  assign unused_gnt_vec = gnt;

  assign cpu_qsel = cpu_addr_i[OFF_W-1:QOFF_W];

  // steer the winner onto the array
  always_comb begin
    acc_we    = 1'b0;
    acc_idx   = '0;
    acc_wdata = '0;
    acc_qwen  = '0;
    unique case (port_e'(sel))
      PORT_DMA: begin
        acc_we    = dma_we_i;
        acc_idx   = dma_addr_i[ADDR_W-1:OFF_W];
        acc_wdata = dma_wdata_i;
        acc_qwen  = dma_qwen_i;
      end
      PORT_CPU: begin
        acc_we    = cpu_we_i;
        acc_idx   = cpu_addr_i[ADDR_W-1:OFF_W];
        acc_wdata = {NQW{cpu_wdata_i}};
        acc_qwen  = NQW'(1) << cpu_qsel;
      end
      PORT_PF: begin
        acc_idx   = pf_addr_i[ADDR_W-1:OFF_W];
      end
      default: ;
    endcase
  end

  lsmem_bank #(
    .LINES  (LINES),
    .LINE_W (LINE_W),
    .NQW    (NQW)
  ) i_bank (
    .clk_i   (clk_i),
    .we_i    (any & acc_we),
    .idx_i   (acc_idx),
    .wdata_i (acc_wdata),
    .qwen_i  (acc_qwen),
    .rdata_o (bank_rdata)
  );

  lsmem_rpipe #(
    .LAT (READ_LAT),
    .DW  (LINE_W),
    .MW  (MW)
  ) i_rpipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (any & ~acc_we),
    .meta_i ({sel, cpu_qsel}),
    .data_i (bank_rdata),
    .v_o    (pipe_v),
    .meta_o (pipe_meta),
    .data_o (pipe_data)
  );

  assign {pipe_port, pipe_qsel} = pipe_meta;

  assign dma_rvalid_o = pipe_v && (port_e'(pipe_port) == PORT_DMA);
  assign cpu_rvalid_o = pipe_v && (port_e'(pipe_port) == PORT_CPU);
  assign pf_rvalid_o  = pipe_v && (port_e'(pipe_port) == PORT_PF);

  assign dma_rdata_o = pipe_data;
  assign pf_rdata_o  = pipe_data;
  assign cpu_rdata_o = pipe_data[pipe_qsel*QW_W +: QW_W];

  // offset bits below the access size are don't-care
  assign unused_addr_bits = ^{dma_addr_i[OFF_W-1:0], pf_addr_i[OFF_W-1:0],
                              cpu_addr_i[QOFF_W-1:0], unused_gnt_vec};
endmodule

// File: rtl/lsmem_arbiter_chk.sv
module lsmem_arbiter_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dma_req_i,
  input logic cpu_req_i,
  input logic pf_req_i,
  input logic dma_gnt_o,
  input logic cpu_gnt_o,
  input logic pf_gnt_o,
  input logic dma_rvalid_o,
  input logic cpu_rvalid_o,
  input logic pf_rvalid_o
);
  a_r1_dma_never_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_i |-> dma_gnt_o);

  a_r2_cpu_yields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o |-> !dma_req_i);

  a_r2_cpu_served: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !dma_gnt_o) |-> cpu_gnt_o);

  a_r3_pf_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_gnt_o |-> (!dma_req_i && !cpu_req_i));

  a_r4_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_gnt_o, cpu_gnt_o, pf_gnt_o}));

  a_r4_grant_has_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({dma_gnt_o, cpu_gnt_o, pf_gnt_o} & ~{dma_req_i, cpu_req_i, pf_req_i}) == 3'b000);

  a_r5_single_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dma_rvalid_o, cpu_rvalid_o, pf_rvalid_o}));

  a_r10_stall_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_req_i && !pf_gnt_o) |-> (dma_req_i || cpu_req_i));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_reset_quiet: assert ({dma_rvalid_o, cpu_rvalid_o, pf_rvalid_o} == 3'b000);
    end
  end
endmodule

bind lsmem_arbiter lsmem_arbiter_chk i_lsmem_arbiter_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dma_req_i    (dma_req_i),
  .cpu_req_i    (cpu_req_i),
  .pf_req_i     (pf_req_i),
  .dma_gnt_o    (dma_gnt_o),
  .cpu_gnt_o    (cpu_gnt_o),
  .pf_gnt_o     (pf_gnt_o),
  .dma_rvalid_o (dma_rvalid_o),
  .cpu_rvalid_o (cpu_rvalid_o),
  .pf_rvalid_o  (pf_rvalid_o)
);

// File: tb/test_lsmem_arbiter.sv
module test_lsmem_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 6;

  typedef struct {
    int            due;
    logic [1023:0] data;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dma_req = 0, dma_we = 0;
  logic [17:0]   dma_addr = '0;
  logic [1023:0] dma_wdata = '0;
  logic [7:0]    dma_qwen = '0;
  logic          dma_gnt, dma_rvalid;
  logic [1023:0] dma_rdata;
  logic          cpu_req = 0, cpu_we = 0;
  logic [17:0]   cpu_addr = '0;
  logic [127:0]  cpu_wdata = '0;
  logic          cpu_gnt, cpu_rvalid;
  logic [127:0]  cpu_rdata;
  logic          pf_req = 0;
  logic [17:0]   pf_addr = '0;
  logic          pf_gnt, pf_rvalid;
  logic [1023:0] pf_rdata;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R5";
  logic [1023:0] model [int];
  exp_t q_dma[$], q_cpu[$], q_pf[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsmem_arbiter i_lsmem_arbiter (
    .clk_i(clk), .rst_ni(rst_n),
    .dma_req_i(dma_req), .dma_we_i(dma_we), .dma_addr_i(dma_addr),
    .dma_wdata_i(dma_wdata), .dma_qwen_i(dma_qwen), .dma_gnt_o(dma_gnt),
    .dma_rvalid_o(dma_rvalid), .dma_rdata_o(dma_rdata),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_gnt_o(cpu_gnt),
    .cpu_rvalid_o(cpu_rvalid), .cpu_rdata_o(cpu_rdata),
    .pf_req_i(pf_req), .pf_addr_i(pf_addr), .pf_gnt_o(pf_gnt),
    .pf_rvalid_o(pf_rvalid), .pf_rdata_o(pf_rdata)
  );

  task automatic chk(bit ok, string tag, string what, logic [1023:0] act, logic [1023:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1023:0] mk(int seed);
    logic [1023:0] r;
    for (int i = 0; i < 32; i++) r[i*32 +: 32] = (seed * 32'h9E3779B1) ^ (i * 32'h01000193) ^ 32'h5A5A0000;
    return r;
  endfunction

  function automatic logic [17:0] la(int line, int off);
    return 18'((line << 7) | (off & 127));
  endfunction

  // driver side: grant check against priority and model update
  task automatic eval();
    logic ed, ec, ep;
    int   idx, qs;
    #1;
    ed = dma_req;
    ec = cpu_req && !dma_req;
    ep = pf_req && !dma_req && !cpu_req;
    chk(dma_gnt === ed, "R1", "dma ready", 1024'(dma_gnt), 1024'(ed));
    chk(cpu_gnt === ec, "R2", "cpu ready", 1024'(cpu_gnt), 1024'(ec));
    chk(pf_gnt === ep,  "R3", "pf ready",  1024'(pf_gnt),  1024'(ep));
    if (ed) begin
      idx = int'(dma_addr[17:7]);
      if (dma_we) begin
        if (!model.exists(idx)) model[idx] = '0;
        for (int q = 0; q < 8; q++) if (dma_qwen[q]) model[idx][q*128 +: 128] = dma_wdata[q*128 +: 128];
      end else q_dma.push_back('{cyc + LAT, model[idx], cur_tag});
    end else if (ec) begin
      idx = int'(cpu_addr[17:7]);
      qs  = int'(cpu_addr[6:4]);
      if (cpu_we) model[idx][qs*128 +: 128] = cpu_wdata;
      else q_cpu.push_back('{cyc + LAT, {896'b0, model[idx][qs*128 +: 128]}, cur_tag});
    end else if (ep) begin
      idx = int'(pf_addr[17:7]);
      q_pf.push_back('{cyc + LAT, model[idx], cur_tag});
    end
  endtask

  task automatic tick();
    eval();
    @(negedge clk);
  endtask

  task automatic mon_port(string nm, logic rv, logic [1023:0] rd, ref exp_t q[$]);
    if (rv) begin
      if (q.size() == 0 || q[0].due != cyc) begin
        chk(0, "R5", {nm, " unexpected rvalid"}, 1024'(cyc), 1024'(q.size() ? q[0].due : -1));
        if (q.size() && q[0].due < cyc) void'(q.pop_front());
      end else begin
        chk(rd === q[0].data, q[0].tag, {nm, " read data"}, rd, q[0].data);
        void'(q.pop_front());
      end
    end else if (q.size() && q[0].due <= cyc) begin
      chk(0, "R5", {nm, " missing rvalid"}, 1024'(cyc), 1024'(q[0].due));
      void'(q.pop_front());
    end
  endtask

  // monitor: compare returns away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      mon_port("dma", dma_rvalid, dma_rdata, q_dma);
      mon_port("cpu", cpu_rvalid, {896'b0, cpu_rdata}, q_cpu);
      mon_port("pf",  pf_rvalid,  pf_rdata,  q_pf);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic idle();
    dma_req = 0; cpu_req = 0; pf_req = 0; dma_we = 0; cpu_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    chk({dma_rvalid, cpu_rvalid, pf_rvalid} === 3'b000, "R11", "rvalid in reset",
        1024'({dma_rvalid, cpu_rvalid, pf_rvalid}), 1024'(0));
    rst_n = 1;
    @(negedge clk);
    chk({dma_rvalid, cpu_rvalid, pf_rvalid} === 3'b000, "R11", "rvalid after reset",
        1024'({dma_rvalid, cpu_rvalid, pf_rvalid}), 1024'(0));

    // R7: full line write and read, offset bits set
    cur_tag = "R7";
    dma_req = 1; dma_we = 1; dma_addr = la(1, 7'h0F); dma_wdata = mk(1); dma_qwen = 8'hFF; tick();
    dma_we = 0; dma_addr = la(1, 7'h43); tick();
    // R6: partial slice write keeps disabled slices
    cur_tag = "R6";
    dma_we = 1; dma_addr = la(1, 0); dma_wdata = mk(2); dma_qwen = 8'hA5; tick();
    dma_we = 0; dma_addr = la(1, 7'h7F); tick();
    // R8/R9: quad-word write and reads
    cur_tag = "R8";
    dma_we = 1; dma_addr = la(2, 0); dma_wdata = mk(3); dma_qwen = 8'hFF; tick();
    idle();
    cpu_req = 1; cpu_we = 1; cpu_addr = la(2, 7'h35); cpu_wdata = 128'hC0FFEE00_11223344_55667788_99AABBCC; tick();
    cur_tag = "R9";
    cpu_we = 0; cpu_addr = la(2, 7'h3A); tick();
    cpu_addr = la(2, 7'h05); tick();
    cpu_addr = la(2, 7'h7C); tick();
    cpu_req = 0;
    cur_tag = "R8";
    dma_req = 1; dma_addr = la(2, 7'h11); tick();
    // R3: lone prefetch served
    idle(); cur_tag = "R3";
    pf_req = 1; pf_addr = la(1, 7'h22); tick();
    idle(); repeat (LAT) tick();

    // R10: stalled write has no effect while DMA reads same line
    cur_tag = "R10";
    dma_req = 1; dma_we = 0; dma_addr = la(1, 0);
    cpu_req = 1; cpu_we = 1; cpu_addr = la(1, 7'h08); cpu_wdata = 128'hDEAD_BEEF;
    pf_req = 1; pf_addr = la(2, 0);
    tick(); tick();
    dma_req = 0; tick();      // cpu write granted
    cpu_req = 0; tick();      // prefetch granted
    pf_req = 0;
    dma_req = 1; dma_addr = la(1, 0); tick();
    idle(); repeat (LAT) tick();

    // R3: prefetch starved by continuous DMA stream
    cur_tag = "R3";
    pf_req = 1; pf_addr = la(1, 0);
    dma_req = 1; dma_we = 0;
    for (int k = 0; k < 24; k++) begin
      dma_addr = la((k % 2) + 1, k);
      #1;
      chk(pf_gnt === 1'b0, "R3", "prefetch starved", 1024'(pf_gnt), 1024'(0));
      #0;
      tick();
    end
    dma_req = 0; tick();      // prefetch now served
    pf_req = 0;
    // R5: back-to-back mixed reads
    cur_tag = "R5";
    cpu_req = 1; cpu_addr = la(1, 7'h60); tick();
    cpu_req = 0; pf_req = 1; pf_addr = la(2, 0); tick();
    pf_req = 0; dma_req = 1; dma_addr = la(1, 0); tick();
    idle();
    repeat (LAT + 3) tick();
    chk(q_dma.size() + q_cpu.size() + q_pf.size() == 0, "R5", "outstanding reads",
        1024'(q_dma.size() + q_cpu.size() + q_pf.size()), 1024'(0));
    finish_run();
  end
endmodule